// File: doc/BRIEF.md
# Logical and shift unit

A combinational 32-bit datapath slice that produces either a bitwise logic result (AND, OR, NOR) of two operands, or a shifted copy of the second operand (logical left, logical right or arithmetic right). The amount of a shift is a 5-bit constant taken from an instruction field. It is never read from a register.

A decoder places the operands, the shift amount and a 3-bit operation code on the inputs. The result is available in the same cycle and has no register stage. A bitwise inversion needs no opcode of its own: it is obtained as NOR of a value with itself, or with zero. The arithmetic right shift rounds toward negative infinity, so it is not a signed division for odd negative values.

Top module: `logic_shift_unit`

## Requirements
- R1: With op_i = 3'b000 the result is a_i AND b_i, bit by bit.
- R2: With op_i = 3'b001 the result is a_i OR b_i, bit by bit.
- R3: With op_i = 3'b010 the result is NOT (a_i OR b_i). When b_i equals a_i or is zero, the result is the bitwise inverse of a_i.
- R4: With op_i = 3'b100 the result is b_i moved toward the MSB by shamt_i positions, and the low positions are filled with zeros (9 shifted by 4 gives 144).
- R5: With op_i = 3'b101 the result is b_i moved toward the LSB by shamt_i positions, and the high positions are filled with zeros.
- R6: With op_i = 3'b110 the result is b_i moved toward the LSB by shamt_i positions, and bit 31 of b_i is copied into the vacated high positions. The shift rounds toward negative infinity: -1 by 1 gives -1, -25 by 4 gives -2, and 25 by 4 gives 1.
- R7: Every shift uses the full 0..31 range of shamt_i and ignores a_i. A shift amount of 0 returns b_i unchanged.
- R8: The unused codes 3'b011 and 3'b111 drive a result of zero, whatever the operands.
- R9: The result is purely combinational. It follows an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand (logic operations only) |
| b_i | input | 32 | Second operand; the value that is shifted |
| shamt_i | input | 5 | Constant shift amount from the instruction field |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Result |

## Verification
The bench targets the arithmetic shift with negative odd values, where a design that rounds toward zero would return -1 for -25 by 4 instead of -2. It also targets shift amounts of 0 and 31, where a barrel stage wired to the wrong amount loses or duplicates the edge bit. A logical right shift of a negative value is checked because a design that reused the sign fill would leave ones at the top. A left shift with a_i set to all ones shows whether the wrong operand is shifted, and the two unused codes show whether stale logic leaks onto the result.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W  = 32;
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_NOR = 3'b010,
    OP_RSV3 = 3'b011,
    OP_SLL = 3'b100,
    OP_SRL = 3'b101,
    OP_SRA = 3'b110,
    OP_RSV7 = 3'b111
  } lsu_op_e;

  typedef struct packed {
    logic sel_logic;
    logic sel_shift;
    logic shift_left;
    logic shift_arith;
    logic [1:0] logic_fn;
  } lsu_ctrl_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int OP_BITS = OP_W
) (
  input  logic [OP_BITS-1:0] op_i,
  output lsu_ctrl_t          ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (op_i)
      OP_AND: begin ctrl_o.sel_logic = 1'b1; ctrl_o.logic_fn = 2'd0; end
      OP_OR:  begin ctrl_o.sel_logic = 1'b1; ctrl_o.logic_fn = 2'd1; end
      OP_NOR: begin ctrl_o.sel_logic = 1'b1; ctrl_o.logic_fn = 2'd2; end
      OP_SLL: begin ctrl_o.sel_shift = 1'b1; ctrl_o.shift_left = 1'b1; end
      OP_SRL: begin ctrl_o.sel_shift = 1'b1; end
      OP_SRA: begin ctrl_o.sel_shift = 1'b1; ctrl_o.shift_arith = 1'b1; end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/lsu_bitwise.sv
module lsu_bitwise #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] and_v, or_v;

  assign and_v = a_i & b_i;
  assign or_v  = a_i | b_i;

  always_comb begin
    unique case (fn_i)
      2'd0:    y_o = and_v;
      2'd1:    y_o = or_v;
      2'd2:    y_o = ~or_v;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/lsu_shifter.sv
// One right-shifting barrel; left shifts mirror the data in and out.
module lsu_shifter #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          left_i,
  input  logic          arith_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] rev_in, rev_out, core_in, core_out;
  logic         fill;
  logic [W-1:0] stg [SW+1];

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = data_i[W-1-i];
    assign rev_out[i] = core_out[W-1-i];
  end

  assign core_in = left_i ? rev_in : data_i;
  assign fill    = arith_i & ~left_i & data_i[W-1];
  assign stg[0]  = core_in;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{STEP{fill}}, stg[s][W-1:STEP]} : stg[s];
  end

  assign core_out = stg[SW];
  assign data_o   = left_i ? rev_out : core_out;
endmodule

// File: rtl/logic_shift_unit.sv
module logic_shift_unit
  import lsu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0]            a_i,
  input  logic [DW-1:0]            b_i,
  input  logic [$clog2(DW)-1:0]    shamt_i,
  input  logic [OP_W-1:0]          op_i,
  output logic [DW-1:0]            result_o
);
  localparam int SW = $clog2(DW);

  lsu_ctrl_t    ctrl;
  logic [DW-1:0] logic_y, shift_y;

  lsu_decode #(.OP_BITS(OP_W)) u_dec (
    .op_i  (op_i),
    .ctrl_o(ctrl)
  );

  lsu_bitwise #(.W(DW)) u_bit (
    .a_i (a_i),
    .b_i (b_i),
    .fn_i(ctrl.logic_fn),
    .y_o (logic_y)
  );

  lsu_shifter #(.W(DW), .SW(SW)) u_shf (
    .data_i (b_i),
    .amt_i  (shamt_i),
    .left_i (ctrl.shift_left),
    .arith_i(ctrl.shift_arith),
    .data_o (shift_y)
  );

  // Unused codes select neither path.
  assign result_o = ({DW{ctrl.sel_logic}} & logic_y) |
                    ({DW{ctrl.sel_shift}} & shift_y);
endmodule

// File: rtl/logic_shift_unit_chk.sv
module logic_shift_unit_chk #(
  parameter int DW = 32
) (
  input logic [DW-1:0]         a_i,
  input logic [DW-1:0]         b_i,
  input logic [$clog2(DW)-1:0] shamt_i,
  input logic [2:0]            op_i,
  input logic [DW-1:0]         result_o
);
  logic [DW-1:0] low_mask;
  logic          known;

  always_comb begin
    low_mask = (DW'(1) << shamt_i) - DW'(1);
    known    = !$isunknown({a_i, b_i, shamt_i, op_i, result_o});
    if (known) begin
      // R1
      and_subset_chk: assert (op_i != 3'b000 || ((result_o & ~a_i) == '0 && (result_o & ~b_i) == '0));
      // R2
      or_superset_chk: assert (op_i != 3'b001 || ((result_o & a_i) == a_i && (result_o & b_i) == b_i));
      // R3
      nor_invert_chk: assert (op_i != 3'b010 || !(a_i == b_i || b_i == '0) || result_o == ~a_i);
      // R4
      sll_low_zero_chk: assert (op_i != 3'b100 || (result_o & low_mask) == '0);
      // R5
      srl_top_zero_chk: assert (op_i != 3'b101 || shamt_i == '0 || result_o[DW-1] == 1'b0);
      // R6
      sra_sign_keep_chk: assert (op_i != 3'b110 || result_o[DW-1] == b_i[DW-1]);
      // R7
      shamt_zero_pass_chk: assert (!(op_i[2] && op_i != 3'b111 && shamt_i == '0) || result_o == b_i);
      // R8
      unused_zero_chk: assert (!(op_i == 3'b011 || op_i == 3'b111) || result_o == '0);
    end
  end
endmodule

bind logic_shift_unit logic_shift_unit_chk #(.DW(DW)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .shamt_i (shamt_i),
  .op_i    (op_i),
  .result_o(result_o)
);

// File: tb/logic_shift_unit_test.sv
module logic_shift_unit_test;
  logic        clk;
  logic [31:0] a, b, res;
  logic [4:0]  sh;
  logic [2:0]  op;
  int          errors = 0;
  int          checks = 0;
  int          cyc    = 0;
  bit          done   = 0;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sh;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 32'hF0F0F0F0, 32'hFF00FF00, 5'd7,  32'hF000F000, 4'd1}, // R1
    '{3'b001, 32'hF0F0F0F0, 32'hFF00FF00, 5'd3,  32'hFFF0FFF0, 4'd2}, // R2
    '{3'b010, 32'h12345678, 32'h12345678, 5'd0,  32'hEDCBA987, 4'd3}, // R3 self
    '{3'b010, 32'h12345678, 32'h00000000, 5'd9,  32'hEDCBA987, 4'd3}, // R3 zero
    '{3'b100, 32'hFFFFFFFF, 32'd9,        5'd4,  32'd144,      4'd4}, // R4
    '{3'b100, 32'h00000000, 32'h00000001, 5'd31, 32'h80000000, 4'd7}, // R7
    '{3'b101, 32'h00000000, 32'h80000000, 5'd31, 32'h00000001, 4'd5}, // R5
    '{3'b101, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd4,  32'h0FFFFFFF, 4'd5}, // R5
    '{3'b110, 32'h00000000, 32'hFFFFFFFF, 5'd1,  32'hFFFFFFFF, 4'd6}, // R6 -1
    '{3'b110, 32'h00000000, 32'hFFFFFFE7, 5'd4,  32'hFFFFFFFE, 4'd6}, // R6 -25
    '{3'b110, 32'h00000000, 32'd25,       5'd4,  32'd1,        4'd6}, // R6 25
    '{3'b110, 32'h00000000, 32'h80000000, 5'd31, 32'hFFFFFFFF, 4'd6}, // R6
    '{3'b101, 32'h55555555, 32'hABCD1234, 5'd0,  32'hABCD1234, 4'd7}, // R7
    '{3'b110, 32'h0,        32'h80000001, 5'd0,  32'h80000001, 4'd7}, // R7
    '{3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd5,  32'h00000000, 4'd8}, // R8
    '{3'b111, 32'hFFFFFFFF, 32'h80000000, 5'd1,  32'h00000000, 4'd8}  // R8
  };

  logic_shift_unit uut (
    .a_i(a), .b_i(b), .shamt_i(sh), .op_i(op), .result_o(res)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] model(logic [2:0] o, logic [31:0] x, logic [31:0] y, logic [4:0] s);
    logic signed [31:0] ys;
    ys = y;
    case (o)
      3'b000:  return x & y;
      3'b001:  return x | y;
      3'b010:  return ~(x | y);
      3'b100:  return y << s;
      3'b101:  return y >> s;
      3'b110:  return ys >>> s;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] exp);
    checks = checks + 1;
    if (res !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: op=%0d a=%h b=%h sh=%0d actual=%h expected=%h",
               req, op, a, b, sh, res, exp);
    end
  endtask

  task automatic apply(logic [2:0] o, logic [31:0] x, logic [31:0] y, logic [4:0] s);
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    #1;
  endtask

  initial begin
    op = 3'b000; a = '0; b = '0; sh = '0;
    // R9 idle inputs: AND of zeros
    apply(3'b000, 32'h0, 32'h0, 5'd0);
    check("R9", 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].sh);
      check($sformatf("R%0d", VECS[i].req), VECS[i].exp);
    end

    // R9: result follows a mid-cycle change with no clock edge
    apply(3'b100, 32'h0, 32'h1, 5'd3);
    b = 32'h3; sh = 5'd30;
    #0.5;
    check("R9", 32'hC0000000);

    // R7: a_i ignored by shifts
    apply(3'b101, 32'h0, 32'hF0000000, 5'd28);
    check("R7", 32'h0000000F);
    a = 32'hFFFFFFFF; #0.5;
    check("R7", 32'h0000000F);

    // R3: NOR with zero operand on the left side too
    apply(3'b010, 32'h0, 32'h0F0F0F0F, 5'd0);
    check("R3", 32'hF0F0F0F0);

    // R1 R2 R3 R4 R5 R6 R8 random against behavioural model
    for (int i = 0; i < 800; i++) begin
      logic [2:0]  ro;
      logic [31:0] ra, rb;
      logic [4:0]  rs;
      ro = 3'($urandom_range(0, 7));
      ra = $urandom;
      rb = (i % 4 == 0) ? (32'h80000000 | $urandom) : $urandom;
      rs = 5'($urandom_range(0, 31));
      apply(ro, ra, rb, rs);
      check($sformatf("R%0d", (ro == 3'b000) ? 1 : (ro == 3'b001) ? 2 : (ro == 3'b010) ? 3 :
                      (ro == 3'b100) ? 4 : (ro == 3'b101) ? 5 : (ro == 3'b110) ? 6 : 8),
            model(ro, ra, rb, rs));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule